// File: doc/BRIEF.md
# Erase-Block Write-Protection Lock Controller

This block keeps a write-protection state for every erase block of a flash array and changes those states in response to host commands. Each block is unlocked, locked, or lock-tight. Lock-tight is sticky: it does not leave that state until a cold reset. The host first sets a block window through a start register and an end register. It then issues one of four range commands: unlock, lock, lock-tight, or unlock-everything.

A command is carried out as a walk over the window, one block per clock. While the walk runs, `busy` is high. When the walk ends, a single-cycle `done` pulse appears. The walk can end normally, stop at a lock-tight block, or stop on an out-of-range index, and `done` pulses in every case. The interrupt flag and the error flag are set on completion and stay set until the next accepted command. A combinational lookup port lets the program and erase logic read the state of any block.

Top module: `wp_lock_ctrl`

## Requirements
- R1: Block states use one-hot codes: lock-tight = 3'b001, locked = 3'b010, unlocked = 3'b100. `lookup_state` returns the state of block `lookup_idx` in the same cycle, and returns 3'b000 for an index at or above NUM_BLOCKS.
- R2: After reset, every block is locked, `wp_status` = 3'b010, both window registers are 0, and `busy`, `done`, `cmd_err` and `irq` are 0.
- R3: Lock (code 8'h2A) visits blocks from the start index up to and including the end index, and makes each one locked. Unlock (code 8'h23) does the same and makes each one unlocked. `wp_status` takes the newly written state. If start is greater than end, the walk changes nothing and takes one busy cycle.
- R4: A lock or unlock walk ends at the first block found in lock-tight. That block stays lock-tight, and no block after it in the window changes.
- R5: Lock-tight (code 8'h2C) visits the same window. It passes over unlocked blocks without changing them or `wp_status`, and it sets every other visited block to lock-tight.
- R6: Unlock-everything (code 8'h27) ignores the window registers. It visits blocks 0 to NUM_BLOCKS-1 and follows the lock-tight stop rule of R4.
- R7: If a walk reaches an index at or above NUM_BLOCKS, `cmd_err` is set and the walk ends there. When an accepted command starts, it clears `cmd_err` and `irq`. Every completed walk sets `irq`.
- R8: The walk keeps `busy` high for exactly one cycle per visited index, counting the index where it stops. `done` is high for one cycle, in the first cycle after `busy` falls.
- R9: A start write stores `wdata[IDX_W-1:0]` into both `start_addr` and `end_addr`. An end write changes only `end_addr`.
- R10: The block ignores a command code other than the four above. It also ignores any command or window write made while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| start_wr | input | 1 | Write strobe for the window start register |
| end_wr | input | 1 | Write strobe for the window end register |
| wdata | input | DATA_W | Write data for the window registers |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| lookup_idx | input | IDX_W | Block index to query |
| lookup_state | output | 3 | State of the queried block |
| start_addr | output | IDX_W | Window start register |
| end_addr | output | IDX_W | Window end register |
| wp_status | output | 3 | Last state written by a walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Range error of the last command |
| irq | output | 1 | Completion interrupt flag |

## Verification
Directed sequences build a known arrangement of lock-tight blocks. Against that arrangement they check the following:
- an unlock-everything stops at the first lock-tight block;
- a lock range stops at the same barrier while later blocks keep their state;
- a lock-tight walk passes over unlocked blocks;
- an empty window (start greater than end) changes nothing;
- a window that runs past the last block sets the error flag.

Further directed cases try an unknown command code, and a command plus a start write issued during a walk, to show that neither is taken. A seeded random mix of window writes and commands then exercises the walk logic. After every command the bench compares the busy length and all block states with a reference model.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;

    typedef enum logic [2:0] {
        WP_TIGHT    = 3'b001,
        WP_LOCKED   = 3'b010,
        WP_UNLOCKED = 3'b100
    } wp_state_e;

    typedef enum logic [1:0] {
        OP_UNLOCK     = 2'd0,
        OP_LOCK       = 2'd1,
        OP_TIGHT      = 2'd2,
        OP_UNLOCK_ALL = 2'd3
    } wp_op_e;

    localparam logic [7:0] CODE_UNLOCK     = 8'h23;
    localparam logic [7:0] CODE_UNLOCK_ALL = 8'h27;
    localparam logic [7:0] CODE_LOCK       = 8'h2A;
    localparam logic [7:0] CODE_TIGHT      = 8'h2C;

endpackage

// File: rtl/wp_state_array.sv
module wp_state_array
    import wp_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int IDX_W      = 4,
    parameter int NUM_RD     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [2:0]       wr_state,
    input  logic [IDX_W-1:0] rd_idx   [NUM_RD],
    output logic [2:0]       rd_state [NUM_RD]
);

    logic [2:0] st_q [NUM_BLOCKS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BLOCKS; i++) begin
                st_q[i] <= WP_LOCKED;
            end
        end else if (wr_en && (int'(wr_idx) < NUM_BLOCKS)) begin
            st_q[wr_idx] <= wr_state;
        end
    end

    // one combinational read port per consumer
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            rd_state[p] = 3'b000;
            if (int'(rd_idx[p]) < NUM_BLOCKS) begin
                rd_state[p] = st_q[rd_idx[p]];
            end
        end
    end

endmodule

// File: rtl/wp_walk_ctrl.sv
module wp_walk_ctrl
    import wp_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    input  logic [IDX_W-1:0] win_start,
    input  logic [IDX_W-1:0] win_end,
    input  logic [2:0]       cur_state,
    output logic [IDX_W-1:0] walk_idx,
    output logic             wr_en,
    output logic [2:0]       wr_state,
    output logic             busy,
    output logic             done,
    output logic             cmd_err,
    output logic             irq,
    output logic [2:0]       wp_status
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);

    typedef struct packed {
        logic             busy;
        wp_op_e           op;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        logic             done;
        logic             err;
        logic             irq;
        logic [2:0]       wp;
    } walk_t;

    walk_t  walk_d, walk_q;
    wp_op_e dec_op;
    logic   dec_ok;
    logic   finish;
    logic [2:0] new_state;

    always_comb begin
        dec_ok = 1'b1;
        dec_op = OP_LOCK;
        unique case (cmd_code)
            CODE_UNLOCK:     dec_op = OP_UNLOCK;
            CODE_UNLOCK_ALL: dec_op = OP_UNLOCK_ALL;
            CODE_LOCK:       dec_op = OP_LOCK;
            CODE_TIGHT:      dec_op = OP_TIGHT;
            default:         dec_ok = 1'b0;
        endcase

        unique case (walk_q.op)
            OP_LOCK:  new_state = WP_LOCKED;
            OP_TIGHT: new_state = WP_TIGHT;
            default:  new_state = WP_UNLOCKED;
        endcase

        walk_d      = walk_q;
        walk_d.done = 1'b0;
        wr_en       = 1'b0;
        finish      = 1'b0;

        if (!walk_q.busy) begin
            if (cmd_valid && dec_ok) begin
                walk_d.busy = 1'b1;
                walk_d.op   = dec_op;
                walk_d.err  = 1'b0;
                walk_d.irq  = 1'b0;
                walk_d.idx  = (dec_op == OP_UNLOCK_ALL) ? '0 : win_start;
                walk_d.last = (dec_op == OP_UNLOCK_ALL) ? LAST_IDX : win_end;
            end
        end else begin
            if (walk_q.idx > walk_q.last) begin
                finish = 1'b1;                      // empty window
            end else if (int'(walk_q.idx) >= NUM_BLOCKS) begin
                walk_d.err = 1'b1;
                finish     = 1'b1;
            end else if ((walk_q.op != OP_TIGHT) && (cur_state == WP_TIGHT)) begin
                finish = 1'b1;                      // barrier reached
            end else begin
                if (!((walk_q.op == OP_TIGHT) && (cur_state == WP_UNLOCKED))) begin
                    wr_en     = 1'b1;
                    walk_d.wp = new_state;
                end
                if (walk_q.idx == walk_q.last) begin
                    finish = 1'b1;
                end else begin
                    walk_d.idx = walk_q.idx + 1'b1;
                end
            end
            if (finish) begin
                walk_d.busy = 1'b0;
                walk_d.done = 1'b1;
                walk_d.irq  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q      <= '0;
            walk_q.op   <= OP_LOCK;
            walk_q.wp   <= WP_LOCKED;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign walk_idx  = walk_q.idx;
    assign wr_state  = new_state;
    assign busy      = walk_q.busy;
    assign done      = walk_q.done;
    assign cmd_err   = walk_q.err;
    assign irq       = walk_q.irq;
    assign wp_status = walk_q.wp;

endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
    import wp_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int DATA_W     = 16,
    localparam int IDX_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              end_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic [IDX_W-1:0]  lookup_idx,
    output logic [2:0]        lookup_state,
    output logic [IDX_W-1:0]  start_addr,
    output logic [IDX_W-1:0]  end_addr,
    output logic [2:0]        wp_status,
    output logic              busy,
    output logic              done,
    output logic              cmd_err,
    output logic              irq
);

    typedef struct packed {
        logic [IDX_W-1:0] start;
        logic [IDX_W-1:0] stop;
    } win_t;

    win_t win_d, win_q;

    logic             wr_en;
    logic [2:0]       wr_state;
    logic [IDX_W-1:0] walk_idx;
    logic [IDX_W-1:0] rd_idx   [2];
    logic [2:0]       rd_state [2];

    always_comb begin
        win_d = win_q;
        if (!busy) begin
            if (start_wr) begin
                win_d.start = wdata[IDX_W-1:0];
                win_d.stop  = wdata[IDX_W-1:0];
            end else if (end_wr) begin
                win_d.stop = wdata[IDX_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign rd_idx[0] = walk_idx;
    assign rd_idx[1] = lookup_idx;

    wp_state_array #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .IDX_W      (IDX_W),
        .NUM_RD     (2)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (walk_idx),
        .wr_state (wr_state),
        .rd_idx   (rd_idx),
        .rd_state (rd_state)
    );

    wp_walk_ctrl #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .IDX_W      (IDX_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .win_start (win_q.start),
        .win_end   (win_q.stop),
        .cur_state (rd_state[0]),
        .walk_idx  (walk_idx),
        .wr_en     (wr_en),
        .wr_state  (wr_state),
        .busy      (busy),
        .done      (done),
        .cmd_err   (cmd_err),
        .irq       (irq),
        .wp_status (wp_status)
    );

    assign lookup_state = rd_state[1];
    assign start_addr   = win_q.start;
    assign end_addr     = win_q.stop;

endmodule

// File: rtl/wp_lock_ctrl_chk.sv
module wp_lock_ctrl_chk #(
    parameter int NUM_BLOCKS = 12,
    parameter int DATA_W     = 16,
    parameter int IDX_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_wr,
    input logic              end_wr,
    input logic [DATA_W-1:0] wdata,
    input logic              cmd_valid,
    input logic [7:0]        cmd_code,
    input logic [IDX_W-1:0]  lookup_idx,
    input logic [2:0]        lookup_state,
    input logic [IDX_W-1:0]  start_addr,
    input logic [IDX_W-1:0]  end_addr,
    input logic [2:0]        wp_status,
    input logic              busy,
    input logic              done,
    input logic              cmd_err,
    input logic              irq
);

    p_lookup_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lookup_idx) < NUM_BLOCKS) |-> $onehot(lookup_state));

    p_lookup_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lookup_idx) >= NUM_BLOCKS) |-> (lookup_state == 3'b000));

    p_wp_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(wp_status));

    p_tight_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_state == 3'b001) |=> (!$stable(lookup_idx) || (lookup_state == 3'b001)));

    p_done_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> irq);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_start_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !busy) |=> (end_addr == start_addr));

    p_win_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(start_addr) && $stable(end_addr)));

    p_wp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(wp_status));

endmodule

bind wp_lock_ctrl wp_lock_ctrl_chk #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W)
) chk_i (.*);

// File: tb/wp_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module wp_lock_ctrl_tb_top;

    localparam int NB = 12;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_wr = 1'b0;
    logic          end_wr = 1'b0;
    logic [15:0]   wdata = '0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = '0;
    logic [IW-1:0] lookup_idx = '0;
    logic [2:0]    lookup_state;
    logic [IW-1:0] start_addr, end_addr;
    logic [2:0]    wp_status;
    logic          busy, done, cmd_err, irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model
    logic [2:0] m_st [NB];
    int         m_start = 0;
    int         m_end = 0;
    logic [2:0] m_wp = 3'b010;
    bit         m_err = 0;
    bit         m_irq = 0;

    always #4 clk = ~clk;

    wp_lock_ctrl #(.NUM_BLOCKS(NB), .DATA_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .end_wr(end_wr),
        .wdata(wdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .lookup_idx(lookup_idx), .lookup_state(lookup_state),
        .start_addr(start_addr), .end_addr(end_addr), .wp_status(wp_status),
        .busy(busy), .done(done), .cmd_err(cmd_err), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // expected walk; returns visited cycles or -1 for an unknown code
    task automatic model_cmd(input logic [7:0] code, output int cycles);
        int lo, hi;
        logic [2:0] ns;
        cycles = 0;
        case (code)
            8'h23: begin ns = 3'b100; lo = m_start; hi = m_end; end
            8'h27: begin ns = 3'b100; lo = 0;       hi = NB - 1; end
            8'h2A: begin ns = 3'b010; lo = m_start; hi = m_end; end
            8'h2C: begin ns = 3'b001; lo = m_start; hi = m_end; end
            default: begin cycles = -1; return; end
        endcase
        m_err = 0;
        m_irq = 1;
        if (lo > hi) begin cycles = 1; return; end
        for (int b = lo; b <= hi; b++) begin
            cycles++;
            if (b >= NB) begin m_err = 1; break; end
            if (code != 8'h2C && m_st[b] == 3'b001) break;
            if (code == 8'h2C && m_st[b] == 3'b100) continue;
            m_st[b] = ns;
            m_wp = ns;
        end
    endtask

    task automatic check_states(input string tag);
        for (int i = 0; i < 16; i++) begin
            lookup_idx = IW'(i);
            #0.2;
            check($sformatf("%s blk%0d", tag, i), int'(lookup_state),
                  (i < NB) ? int'(m_st[i]) : 0);
        end
        @(negedge clk);
    endtask

    task automatic wr_start(input logic [15:0] v);
        start_wr = 1'b1; wdata = v;
        @(negedge clk);
        start_wr = 1'b0;
        m_start = int'(v[IW-1:0]);
        m_end = m_start;
        check("R9 start", int'(start_addr), m_start);
        check("R9 end mirror", int'(end_addr), m_end);
    endtask

    task automatic wr_end(input logic [15:0] v);
        end_wr = 1'b1; wdata = v;
        @(negedge clk);
        end_wr = 1'b0;
        m_end = int'(v[IW-1:0]);
        check("R9 end only", int'(end_addr), m_end);
        check("R9 start kept", int'(start_addr), m_start);
    endtask

    task automatic run_cmd(input logic [7:0] code, input string tag);
        int exp_c, n;
        model_cmd(code, exp_c);
        cmd_valid = 1'b1; cmd_code = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (exp_c < 0) begin
            check({tag, " R10 busy"}, int'(busy), 0);
            @(negedge clk);
            check({tag, " R10 done"}, int'(done), 0);
            check({tag, " R10 irq"}, int'(irq), int'(m_irq));
            check_states({tag, " R10"});
            return;
        end
        n = 0;
        while (busy && n < 64) begin n++; @(negedge clk); end
        check({tag, " R8 cycles"}, n, exp_c);
        check({tag, " R8 done"}, int'(done), 1);
        check({tag, " R7 irq"}, int'(irq), 1);
        check({tag, " R7 err"}, int'(cmd_err), int'(m_err));
        check({tag, " R3 wp"}, int'(wp_status), int'(m_wp));
        @(negedge clk);
        check({tag, " R8 done pulse"}, int'(done), 0);
        check_states(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        int exp_c, n;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < NB; i++) m_st[i] = 3'b010;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        check("R2 busy", int'(busy), 0);
        check("R2 done", int'(done), 0);
        check("R2 err", int'(cmd_err), 0);
        check("R2 irq", int'(irq), 0);
        check("R2 wp", int'(wp_status), 3'b010);
        check("R2 start", int'(start_addr), 0);
        check("R2 end", int'(end_addr), 0);
        check_states("R2 R1");

        // R3 unlock range 2..5
        wr_start(16'hff02);
        wr_end(16'h0005);
        run_cmd(8'h23, "R3 unlock");
        // R5 lock-tight single, then range skipping unlocked
        wr_start(16'h0006);
        run_cmd(8'h2C, "R5 tight one");
        wr_start(16'h0004);
        wr_end(16'h0006);
        run_cmd(8'h2C, "R5 skip");
        // R6 unlock-all stops at block 6
        run_cmd(8'h27, "R6 R4 unlock all");
        // R4 lock range stops at barrier
        wr_start(16'h0003);
        wr_end(16'h0009);
        run_cmd(8'h2A, "R4 lock barrier");
        // R7 range past the last block
        wr_start(16'h000a);
        wr_end(16'h000d);
        run_cmd(8'h23, "R7 overrun");
        // R3 empty window, also clears error (R7)
        wr_start(16'h0005);
        wr_end(16'h0003);
        run_cmd(8'h2A, "R3 R7 empty");
        // R10 unknown code
        run_cmd(8'h55, "R10 bad code");

        // R10 writes and commands during a walk
        wr_start(16'h0007);
        wr_end(16'h000b);
        model_cmd(8'h2A, exp_c);
        cmd_valid = 1'b1; cmd_code = 8'h2A;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 1;
        @(negedge clk);
        start_wr = 1'b1; wdata = 16'h0002; cmd_valid = 1'b1; cmd_code = 8'h23;
        @(negedge clk);
        start_wr = 1'b0; cmd_valid = 1'b0;
        n = 2;
        while (busy && n < 64) begin n++; @(negedge clk); end
        check("R10 R8 busy cycles", n, exp_c);
        check("R10 start kept", int'(start_addr), 7);
        check("R10 end kept", int'(end_addr), 11);
        @(negedge clk);
        check("R10 no second walk", int'(busy), 0);
        check_states("R10 busy ignore");

        // random mix
        for (int it = 0; it < 250; it++) begin
            int r;
            r = int'($urandom % 7);
            case (r)
                0, 1: wr_start(16'($urandom));
                2:    wr_end(16'($urandom));
                default: begin
                    logic [7:0] c;
                    case ($urandom % 9)
                        0, 1: c = 8'h23;
                        2:    c = 8'h27;
                        3, 4: c = 8'h2A;
                        5:    c = 8'h2C;
                        6:    c = 8'h23;
                        7:    c = 8'h2A;
                        default: c = 8'h71;
                    endcase
                    run_cmd(c, "R3 R4 R5 R6 random");
                end
            endcase
        end

        finish_up();
    end

endmodule